// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This combinational unit computes the result byte and the updated flag byte for an 8-bit processor's extended rotate/shift group, its bit test, bit set and bit clear operations, and the four one-byte accumulator rotates. The caller presents an operand, the current flag byte, a two-bit group code, a three-bit operation/bit field, and a short-form qualifier. The unit returns the new operand value and the new flags in the same cycle. A separate input carries the high byte of the address latch. Bit tests on a memory operand take the undocumented flag bits 3 and 5 from that byte.

The flag byte layout is fixed: bit 7 sign (S), bit 6 zero (Z), bit 5 copy bit (Y), bit 4 half carry (H), bit 3 copy bit (X), bit 2 parity/overflow (P), bit 1 subtract (N), bit 0 carry (C). The group code is 0 for rotate/shift, 1 for bit test, 2 for bit clear and 3 for bit set. The unit has no state. Its dispatch is one unique case over the group code, GRP_ROT, GRP_TEST, GRP_RES and GRP_SET. Inside GRP_ROT a second choice picks between the full form, the short accumulator form and the short-form pass-through.

Top module: `rsb_unit`

## Requirements
- R1: In group 0, the op field selects the operation: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left with 0 in, 5 shift right keeping bit 7, 6 shift left with 1 in, 7 shift right with 0 in.
- R2: Every group-0 rotate or shift writes the bit shifted out to C. It clears N and H and copies result bits 5 and 3 into flag bits 5 (Y) and 3 (X).
- R3: The full form (short flag low) sets S to result bit 7 and sets Z when the result is zero. It sets P when the result has an even count of ones.
- R4: The short form (short flag high, op 0 to 3) gives the same result and C as the full form. It leaves S, Z and P at their incoming values.
- R5: The short form with op 4 to 7 returns the operand and the flag byte unchanged.
- R6: Bit test (group 1) sets Z when operand bit `op` is 0 and sets P equal to Z. It sets H, clears N and keeps C. It sets S only when bit 7 is tested and is 1. The result equals the operand.
- R7: In a bit test, flag bits 5 and 3 come from the operand when the memory-source input is low. They come from the latch high byte when that input is high.
- R8: Bit clear (group 2) and bit set (group 3) force operand bit `op` to 0 or 1 and keep the other bits. The flag byte passes through unchanged.
- R9: The short flag has no effect outside group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_i | input | 8 | Operand byte |
| flg_i | input | 8 | Incoming flag byte |
| grp_i | input | 2 | Group: 0 rotate/shift, 1 test, 2 clear, 3 set |
| sel_i | input | 3 | Operation (group 0) or bit index |
| short_i | input | 1 | Short accumulator-rotate form |
| mem_src_i | input | 1 | Bit test operand came from memory |
| lat_hi_i | input | 8 | High byte of the internal address latch |
| res_o | output | 8 | Result byte |
| flg_o | output | 8 | Updated flag byte |

## Verification
The bench builds the unit with its default package constants: an 8-bit data path and the fixed flag layout. That configuration reaches all eight shift encodings, every group, both flag-3/5 sources of the bit test and the short-form pass-through.

The vector table is chosen to push an out-shifted bit into C and to produce zero results, which set Z and P. It covers bit 7 tests, which drive S, and incoming carries that must survive. A directed step checks the all-zero input case, and further steps pair the short flag with groups where it must do nothing.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    localparam int DW = 8;
    localparam int SW = $clog2(DW);

    localparam int F_S = 7;
    localparam int F_Z = 6;
    localparam int F_Y = 5;
    localparam int F_H = 4;
    localparam int F_X = 3;
    localparam int F_P = 2;
    localparam int F_N = 1;
    localparam int F_C = 0;

    typedef enum logic [1:0] {
        GRP_ROT  = 2'd0,
        GRP_TEST = 2'd1,
        GRP_RES  = 2'd2,
        GRP_SET  = 2'd3
    } grp_e;

    typedef enum logic [SW-1:0] {
        OP_RLC = 3'd0,
        OP_RRC = 3'd1,
        OP_RL  = 3'd2,
        OP_RR  = 3'd3,
        OP_SLA = 3'd4,
        OP_SRA = 3'd5,
        OP_SLL = 3'd6,
        OP_SRL = 3'd7
    } rot_e;

    function automatic logic even_par(input logic [DW-1:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
(
    input  logic [DW-1:0] opd_i,
    input  logic          cin_i,
    input  logic [SW-1:0] op_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    always_comb begin
        res_o  = opd_i;
        cout_o = 1'b0;
        unique case (rot_e'(op_i))
            OP_RLC: begin res_o = {opd_i[DW-2:0], opd_i[DW-1]}; cout_o = opd_i[DW-1]; end
            OP_RRC: begin res_o = {opd_i[0], opd_i[DW-1:1]};    cout_o = opd_i[0];    end
            OP_RL:  begin res_o = {opd_i[DW-2:0], cin_i};       cout_o = opd_i[DW-1]; end
            OP_RR:  begin res_o = {cin_i, opd_i[DW-1:1]};       cout_o = opd_i[0];    end
            OP_SLA: begin res_o = {opd_i[DW-2:0], 1'b0};        cout_o = opd_i[DW-1]; end
            OP_SRA: begin res_o = {opd_i[DW-1], opd_i[DW-1:1]}; cout_o = opd_i[0];    end
            OP_SLL: begin res_o = {opd_i[DW-2:0], 1'b1};        cout_o = opd_i[DW-1]; end
            OP_SRL: begin res_o = {1'b0, opd_i[DW-1:1]};        cout_o = opd_i[0];    end
        endcase
    end

    always_comb begin
        if (!$isunknown({opd_i, op_i, cin_i})) begin
            AST_ROT_CARRY_OUT: assert (cout_o == ((op_i[0]) ? opd_i[0] : opd_i[DW-1])); // R2
        end
    end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
    import rsb_pkg::*;
(
    input  logic [DW-1:0] opd_i,
    input  logic [SW-1:0] idx_i,
    input  logic          val_i,
    output logic [DW-1:0] res_o,
    output logic          bit_o
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign res_o[i] = (idx_i == SW'(i)) ? val_i : opd_i[i];
    end

    assign bit_o = opd_i[idx_i];

    always_comb begin
        if (!$isunknown({opd_i, idx_i, val_i})) begin
            AST_BITOP_ONE_CHANGE: assert ($countones(res_o ^ opd_i) <= 1); // R8
        end
    end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
(
    input  logic [7:0] opd_i,
    input  logic [7:0] flg_i,
    input  logic [1:0] grp_i,
    input  logic [2:0] sel_i,
    input  logic       short_i,
    input  logic       mem_src_i,
    input  logic [7:0] lat_hi_i,
    output logic [7:0] res_o,
    output logic [7:0] flg_o
);
    logic [DW-1:0] sh_res;
    logic          sh_cout;
    logic [DW-1:0] bo_res;
    logic          bo_bit;
    logic [DW-1:0] xy_src;
    grp_e          grp;

    assign grp = grp_e'(grp_i);

    rsb_shifter u_shift (
        .opd_i  (opd_i),
        .cin_i  (flg_i[F_C]),
        .op_i   (sel_i),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    rsb_bitop u_bitop (
        .opd_i (opd_i),
        .idx_i (sel_i),
        .val_i (grp == GRP_SET),
        .res_o (bo_res),
        .bit_o (bo_bit)
    );

    assign xy_src = mem_src_i ? lat_hi_i : opd_i;

    always_comb begin
        res_o = opd_i;
        flg_o = flg_i;
        unique case (grp)
            GRP_ROT: begin
                if (short_i && sel_i[SW-1]) begin
                    res_o = opd_i;
                    flg_o = flg_i;
                end else begin
                    res_o      = sh_res;
                    flg_o[F_C] = sh_cout;
                    flg_o[F_N] = 1'b0;
                    flg_o[F_H] = 1'b0;
                    flg_o[F_Y] = sh_res[F_Y];
                    flg_o[F_X] = sh_res[F_X];
                    if (!short_i) begin
                        flg_o[F_S] = sh_res[DW-1];
                        flg_o[F_Z] = (sh_res == '0);
                        flg_o[F_P] = even_par(sh_res);
                    end
                end
            end
            GRP_TEST: begin
                res_o      = opd_i;
                flg_o[F_Z] = ~bo_bit;
                flg_o[F_P] = ~bo_bit;
                flg_o[F_S] = bo_bit && (sel_i == SW'(DW-1));
                flg_o[F_H] = 1'b1;
                flg_o[F_N] = 1'b0;
                flg_o[F_Y] = xy_src[F_Y];
                flg_o[F_X] = xy_src[F_X];
            end
            GRP_RES, GRP_SET: begin
                res_o = bo_res;
                flg_o = flg_i;
            end
        endcase
    end

    always_comb begin
        if (!$isunknown({opd_i, flg_i, grp_i, sel_i, short_i, mem_src_i, lat_hi_i})) begin
            if (grp_i == 2'd2) AST_CLR_BIT_LOW: assert (res_o[sel_i] == 1'b0 && flg_o == flg_i); // R8
            if (grp_i == 2'd3) AST_SET_BIT_HIGH: assert (res_o[sel_i] == 1'b1 && flg_o == flg_i); // R8
            if (grp_i == 2'd1) AST_TEST_KEEPS_CARRY: assert (res_o == opd_i && flg_o[0] == flg_i[0] && flg_o[6] == flg_o[2]); // R6
            if (grp_i == 2'd0 && !(short_i && sel_i[2])) AST_ROT_CLEARS_NH: assert (flg_o[1] == 1'b0 && flg_o[4] == 1'b0); // R2
            if (grp_i == 2'd0 && short_i && !sel_i[2]) AST_SHORT_KEEPS_SZP: assert (flg_o[7] == flg_i[7] && flg_o[6] == flg_i[6] && flg_o[2] == flg_i[2]); // R4
            if (grp_i == 2'd0 && short_i && sel_i[2]) AST_SHORT_PASS: assert (res_o == opd_i && flg_o == flg_i); // R5
        end
    end
endmodule

// File: tb/sim_rsb_unit.sv
module sim_rsb_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [1:0] grp;
        logic [2:0] sel;
        logic       sh;
        logic       mem;
        logic [7:0] opd;
        logic [7:0] flg;
        logic [7:0] lat;
        logic [7:0] eres;
        logic [7:0] eflg;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd0, 1'b0, 1'b0, 8'h81, 8'h00, 8'h00, 8'h03, 8'h05, 8'd1}, // R1 R3 rlc
        '{2'd0, 3'd1, 1'b0, 1'b0, 8'h01, 8'h00, 8'h00, 8'h80, 8'h81, 8'd1}, // R1 rrc
        '{2'd0, 3'd2, 1'b0, 1'b0, 8'h80, 8'h00, 8'h00, 8'h00, 8'h45, 8'd3}, // R3 rl zero
        '{2'd0, 3'd3, 1'b0, 1'b0, 8'h50, 8'h01, 8'h00, 8'hA8, 8'hA8, 8'd2}, // R2 rr xy copy
        '{2'd0, 3'd4, 1'b0, 1'b0, 8'hC1, 8'hFF, 8'h00, 8'h82, 8'h85, 8'd2}, // R2 sla clears N H
        '{2'd0, 3'd5, 1'b0, 1'b0, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h85, 8'd1}, // R1 sra
        '{2'd0, 3'd6, 1'b0, 1'b0, 8'h84, 8'h00, 8'h00, 8'h09, 8'h0D, 8'd1}, // R1 sll
        '{2'd0, 3'd7, 1'b0, 1'b0, 8'h01, 8'hFE, 8'h00, 8'h00, 8'h45, 8'd3}, // R3 srl
        '{2'd0, 3'd0, 1'b1, 1'b0, 8'h80, 8'hC4, 8'h00, 8'h01, 8'hC5, 8'd4}, // R4 short rlc
        '{2'd0, 3'd3, 1'b1, 1'b0, 8'h11, 8'h00, 8'h00, 8'h08, 8'h09, 8'd4}, // R4 short rr
        '{2'd0, 3'd5, 1'b1, 1'b0, 8'h5A, 8'h93, 8'h00, 8'h5A, 8'h93, 8'd5}, // R5 short pass
        '{2'd1, 3'd3, 1'b0, 1'b0, 8'h08, 8'h01, 8'h00, 8'h08, 8'h19, 8'd6}, // R6 bit set
        '{2'd1, 3'd7, 1'b0, 1'b0, 8'h80, 8'h00, 8'h00, 8'h80, 8'h90, 8'd6}, // R6 bit7 sign
        '{2'd1, 3'd2, 1'b0, 1'b1, 8'hFB, 8'hFE, 8'h28, 8'hFB, 8'h7C, 8'd7}, // R7 latch xy
        '{2'd1, 3'd0, 1'b0, 1'b0, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h55, 8'd7}, // R7 operand xy
        '{2'd2, 3'd4, 1'b0, 1'b0, 8'hFF, 8'h5A, 8'h00, 8'hEF, 8'h5A, 8'd8}, // R8 clear
        '{2'd3, 3'd1, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h00, 8'h02, 8'hA5, 8'd8}, // R8 set
        '{2'd3, 3'd7, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'd9}, // R9 short with set
        '{2'd1, 3'd6, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h54, 8'd9}  // R9 short with test
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opd = '0;
    logic [7:0] flg = '0;
    logic [1:0] grp = '0;
    logic [2:0] sel = '0;
    logic       sh  = 1'b0;
    logic       mem = 1'b0;
    logic [7:0] lat = '0;
    logic [7:0] res_w;
    logic [7:0] flg_w;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsb_unit u0 (
        .opd_i     (opd),
        .flg_i     (flg),
        .grp_i     (grp),
        .sel_i     (sel),
        .short_i   (sh),
        .mem_src_i (mem),
        .lat_hi_i  (lat),
        .res_o     (res_w),
        .flg_o     (flg_w)
    );

    task automatic check(input int req, input logic [7:0] er, input logic [7:0] ef);
        checks++;
        if (res_w !== er || flg_w !== ef) begin
            fails++;
            $display("FAIL R%0d: res=%02h flg=%02h expected res=%02h flg=%02h", req, res_w, flg_w, er, ef);
        end
    endtask

    task automatic apply(input vec_t v);
        @(posedge clk);
        grp = v.grp; sel = v.sel; sh = v.sh; mem = v.mem;
        opd = v.opd; flg = v.flg; lat = v.lat;
        @(negedge clk);
        check(int'(v.req), v.eres, v.eflg);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle inputs: rlc of zero gives zero with Z and P set (R3)
        @(negedge clk);
        check(3, 8'h00, 8'h44);
        for (int i = 0; i < NVEC; i++) apply(VECS[i]);
        // R5 corner: short sll must not inject a 1
        apply('{2'd0, 3'd6, 1'b1, 1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 8'h01, 8'd5});
        // R1 R2 rl pulls carry into bit 0
        apply('{2'd0, 3'd2, 1'b0, 1'b0, 8'h7F, 8'h01, 8'h00, 8'hFF, 8'hAC, 8'd2});
        // R6 tested bit clear on all-ones except bit 5
        apply('{2'd1, 3'd5, 1'b0, 1'b0, 8'hDF, 8'h00, 8'h00, 8'hDF, 8'h5C, 8'd6});
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule